// File: doc/BRIEF.md
# Grouped Interrupt Status Encoder

The block collects interrupt requests from three source groups: a small critical group, a main group and a peripheral group. The main and peripheral groups each pass through a disable mask. In each group the block picks the lowest-numbered live source. It then packs the three results into one status word, and each group has its own field and its own valid bit. A single summary request output is high whenever any field is valid. The status word is computed combinationally from the requests and the register state, then registered once. The word and the summary request therefore follow the inputs by one clock.

Two peripheral sources can be promoted. One is promoted to high priority and one to medium priority. When a promoted source is the selected peripheral source, a reserved code appears in the critical field or the main field. That code tells the handler to read the peripheral field instead. A genuine critical or main request always takes precedence over the reserved code. The peripheral field always names the real source.

Software reaches the two mask registers and the two promotion registers through a small register port. Writes use a write strobe. Read data is combinational.

Top module: `grp_irq_encoder`

## Requirements
- R1: After reset, irq_status is 0 and irq_pend is 0. Reading address 0 returns 0x00010fff, address 1 returns 0x7ffffc00, and addresses 2 and 3 return 0.
- R2: Critical field: bit 10 is valid, and bits [9:8] hold the lowest-numbered active critical request. Critical request 2 is ignored, because code 2 is reserved.
- R3: Main field: bit 21 is valid, and bits [20:16] hold the lowest-numbered unmasked active main request. Main source n is disabled by bit 16-n of the main mask (address 0). Main request 4 is ignored, because code 4 is reserved.
- R4: Peripheral field: bit 29 is valid, and bits [28:24] hold the lowest-numbered unmasked active peripheral request. Peripheral source n is disabled by bit 31-n of the peripheral mask (address 1). Source 0 is an ordinary input.
- R5: All three fields are reported at the same time. A field whose valid bit is 0 reads as 0, and every other status bit is always 0.
- R6: High-priority promotion uses address 2, with bit 5 as enable and bits [4:0] as the source. When the enabled source is the selected peripheral source and no critical request is active, the critical field shows valid with code 2.
- R7: Medium-priority promotion uses address 3, with the same format as address 2. When the enabled source is the selected peripheral source and no unmasked main request is active, the main field shows valid with code 4.
- R8: irq_pend is 1 exactly when at least one of status bits 10, 21 and 29 is 1.
- R9: A change on the requests is visible on irq_status one clock edge later, and not before.
- R10: A write with reg_wr high at a clock edge loads reg_wdata into the register selected by reg_addr, and that value takes effect from that edge. reg_rdata returns the selected register combinationally. The promotion registers keep only bits [5:0].
- R11: A mask bit of 1 disables its source, so an unmasked source above a masked one is reported instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| crit_req | input | CRIT_N | Critical group requests |
| main_req | input | MAIN_N | Main group requests |
| peri_req | input | PERI_N | Peripheral group requests |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 main mask, 1 peripheral mask, 2 high promotion, 3 medium promotion |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| irq_status | output | 32 | Registered encoded status word |
| irq_pend | output | 1 | Any group pending |

## Verification
The bench builds the block with its default parameters: 4 critical, 17 main and 32 peripheral sources, with the reset mask values listed in R1. These defaults make every mask bit position reachable, including the edge bits that serve main source 16 and peripheral source 0. They also make both reserved codes reachable, so the bench can collide promoted sources with genuine critical and main requests.

// File: rtl/grp_irq_encoder.sv
module grp_irq_encoder #(
  parameter int          CRIT_N        = 4,
  parameter int          MAIN_N        = 17,
  parameter int          PERI_N        = 32,
  parameter int          CRIT_HI_CODE  = 2,
  parameter int          MAIN_MED_CODE = 4,
  parameter logic [31:0] MAIN_MASK_RST = 32'h0001_0fff,
  parameter logic [31:0] PERI_MASK_RST = 32'h7fff_fc00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CRIT_N-1:0] crit_req,
  input  logic [MAIN_N-1:0] main_req,
  input  logic [PERI_N-1:0] peri_req,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [31:0]       irq_status,
  output logic              irq_pend
);

  localparam int MAIN_TOP = 16;
  localparam int PERI_TOP = 31;
  localparam int CW = 2;
  localparam int MW = 5;
  localparam int PW = 5;
  localparam int BW = PW + 1;

  logic [31:0]       main_mask, peri_mask;
  logic [BW-1:0]     boost_hi, boost_med;
  logic [CRIT_N-1:0] crit_live;
  logic [MAIN_N-1:0] main_live;
  logic [PERI_N-1:0] peri_live;
  logic [CW-1:0]     c_idx;
  logic [MW-1:0]     m_idx;
  logic [PW-1:0]     p_idx;
  logic              c_hit, m_hit, p_hit, hi_up, med_up;
  logic [31:0]       status_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_mask <= MAIN_MASK_RST;
      peri_mask <= PERI_MASK_RST;
      boost_hi  <= '0;
      boost_med <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        2'd0: main_mask <= reg_wdata;
        2'd1: peri_mask <= reg_wdata;
        2'd2: boost_hi  <= reg_wdata[BW-1:0];
        default: boost_med <= reg_wdata[BW-1:0];
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0: reg_rdata = main_mask;
      2'd1: reg_rdata = peri_mask;
      2'd2: reg_rdata = {{(32-BW){1'b0}}, boost_hi};
      default: reg_rdata = {{(32-BW){1'b0}}, boost_med};
    endcase
  end

  always_comb begin
    for (int i = 0; i < CRIT_N; i++) crit_live[i] = crit_req[i] && (i != CRIT_HI_CODE);
    for (int i = 0; i < MAIN_N; i++)
      main_live[i] = main_req[i] && !main_mask[MAIN_TOP-i] && (i != MAIN_MED_CODE);
    for (int i = 0; i < PERI_N; i++) peri_live[i] = peri_req[i] && !peri_mask[PERI_TOP-i];
  end

  always_comb begin
    c_idx = '0;
    m_idx = '0;
    p_idx = '0;
    for (int i = CRIT_N-1; i >= 0; i--) if (crit_live[i]) c_idx = CW'(i);
    for (int i = MAIN_N-1; i >= 0; i--) if (main_live[i]) m_idx = MW'(i);
    for (int i = PERI_N-1; i >= 0; i--) if (peri_live[i]) p_idx = PW'(i);
  end

  assign c_hit  = |crit_live;
  assign m_hit  = |main_live;
  assign p_hit  = |peri_live;
  assign hi_up  = p_hit && boost_hi[PW]  && (boost_hi[PW-1:0]  == p_idx);
  assign med_up = p_hit && boost_med[PW] && (boost_med[PW-1:0] == p_idx);

  always_comb begin
    status_d = '0;
    if (c_hit)      status_d[10:8] = {1'b1, c_idx};
    else if (hi_up) status_d[10:8] = {1'b1, CW'(CRIT_HI_CODE)};
    if (m_hit)       status_d[21:16] = {1'b1, m_idx};
    else if (med_up) status_d[21:16] = {1'b1, MW'(MAIN_MED_CODE)};
    if (p_hit)      status_d[29:24] = {1'b1, p_idx};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_status <= '0;
      irq_pend   <= 1'b0;
    end else begin
      irq_status <= status_d;
      irq_pend   <= c_hit | m_hit | p_hit;
    end
  end

  // R2
  crit_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_hit |=> irq_status[10]);
  // R3
  main_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_hit |=> irq_status[21]);
  // R4
  peri_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_hit |=> irq_status[29]);
  // R5
  zero_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_status & 32'hC0C0_F8FF) == 32'h0) &&
    (irq_status[10] || irq_status[9:8] == 2'd0) &&
    (irq_status[21] || irq_status[20:16] == 5'd0) &&
    (irq_status[29] || irq_status[28:24] == 5'd0));
  // R6
  hi_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_status[10] && irq_status[9:8] == CW'(CRIT_HI_CODE)) |-> irq_status[29]);
  // R7
  med_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_status[21] && irq_status[20:16] == MW'(MAIN_MED_CODE)) |-> irq_status[29]);
  // R8
  pend_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend == (irq_status[10] | irq_status[21] | irq_status[29]));

endmodule

// File: tb/grp_irq_encoder_tb.sv
module grp_irq_encoder_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  crit_req = '0;
  logic [16:0] main_req = '0;
  logic [31:0] peri_req = '0;
  logic        reg_wr = 0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, irq_status;
  logic        irq_pend;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  grp_irq_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .crit_req(crit_req), .main_req(main_req),
    .peri_req(peri_req), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_status(irq_status),
    .irq_pend(irq_pend));

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(posedge clk); @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic drive(input logic [3:0] c, input logic [16:0] m, input logic [31:0] p);
    crit_req = c; main_req = m; peri_req = p;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 status", irq_status, 0);
    check("R1 pend", {31'b0, irq_pend}, 0);
    reg_addr = 0; #1 check("R1 main mask", reg_rdata, 32'h0001_0fff);
    reg_addr = 1; #1 check("R1 peri mask", reg_rdata, 32'h7fff_fc00);
    reg_addr = 2; #1 check("R1 boost hi", reg_rdata, 0);
    reg_addr = 3; #1 check("R1 boost med", reg_rdata, 0);
  endtask

  task automatic t_crit;
    drive(4'b1100, 0, 0); check("R2 skip code2", irq_status, 32'h0000_0700);
    check("R8 pend", {31'b0, irq_pend}, 1);
    drive(4'b0100, 0, 0); check("R2 code2 ignored", irq_status, 0);
    check("R8 idle", {31'b0, irq_pend}, 0);
    drive(4'b0011, 0, 0); check("R2 lowest", irq_status, 32'h0000_0400);
  endtask

  task automatic t_main;
    drive(0, 17'h00005, 0); check("R3 reset mask", irq_status, 32'h0022_0000);
    drive(0, 17'h00010, 0); check("R3 code4 ignored", irq_status, 0);
    wr(0, 0);
    drive(0, 17'h00005, 0); check("R3 unmasked src0", irq_status, 32'h0020_0000);
    drive(0, 17'h10000, 0); check("R3 src16", irq_status, 32'h0030_0000);
    wr(0, 32'h1);
    drive(0, 17'h10200, 0); check("R11 main bit0", irq_status, 32'h0029_0000);
    drive(0, 17'h10000, 0); check("R11 src16 off", irq_status, 0);
  endtask

  task automatic t_peri;
    drive(0, 0, 32'h0200_0020); check("R4 reset mask", irq_status, 32'h3900_0000);
    drive(0, 0, 32'h0000_0001); check("R4 src0", irq_status, 32'h2000_0000);
    wr(1, 32'hffff_ffff);
    drive(0, 0, 32'hffff_ffff); check("R11 all off", irq_status, 0);
    wr(1, 0);
    reg_addr = 1; #1 check("R10 readback", reg_rdata, 0);
    drive(0, 0, 32'h0200_0020); check("R4 unmasked", irq_status, 32'h2500_0000);
  endtask

  task automatic t_all;
    wr(0, 0);
    drive(4'b0010, 17'h00008, 32'h0000_0080);
    check("R5 all fields", irq_status, 32'h2723_0500);
  endtask

  task automatic t_boost_hi;
    wr(2, 32'hffff_ffe7);
    reg_addr = 2; #1 check("R10 boost bits", reg_rdata, 32'h27);
    drive(0, 0, 32'h0000_0080); check("R6 sentinel", irq_status, 32'h2700_0600);
    drive(4'b0001, 0, 32'h0000_0080); check("R6 genuine wins", irq_status, 32'h2700_0400);
    drive(0, 0, 32'h0000_0088); check("R6 not selected", irq_status, 32'h2300_0000);
    wr(2, 32'h07);
    drive(0, 0, 32'h0000_0080); check("R6 disabled", irq_status, 32'h2700_0000);
  endtask

  task automatic t_boost_med;
    wr(3, 32'h29);
    drive(0, 0, 32'h0000_0200); check("R7 sentinel", irq_status, 32'h2924_0000);
    drive(0, 17'h00002, 32'h0000_0200); check("R7 genuine wins", irq_status, 32'h2921_0000);
    wr(2, 32'h29);
    drive(0, 0, 32'h0000_0200); check("R7 both codes", irq_status, 32'h2924_0600);
    check("R8 pend", {31'b0, irq_pend}, 1);
  endtask

  task automatic t_latency;
    drive(0, 0, 0);
    crit_req = 4'b0001;
    #1 check("R9 not yet", irq_status, 0);
    @(posedge clk); @(negedge clk);
    check("R9 one edge", irq_status, 32'h0000_0400);
    crit_req = 0;
    #1 check("R9 hold", irq_status, 32'h0000_0400);
    @(posedge clk); @(negedge clk);
    check("R9 clear", irq_status, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_crit;
    t_main;
    t_peri;
    t_all;
    t_boost_hi;
    t_boost_med;
    t_latency;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule